// File: doc/BRIEF.md
# Power and Clock Control Register Bank

This block is the host-facing control store for a radio modem's power sequencing and clock setup. A host writes single bytes through a write strobe, an address and a data bus. Three locations are decoded. The first power register holds general enables, and one of its bits (the regulator enable) survives a soft reset. The second power register drives four auxiliary converter enables, an external low-noise-amplifier pin, a preserve flag, the soft-reset bit and a bias enable. The clock register holds a reference divider code and a base-clock multiplier code.

Writing the soft-reset bit as 1 clears the power state, except for the regulator bit, the bias bit and the preserve flag. The clock register is not touched. The block then holds the converter enables and the amplifier pin off. Software can leave reset only through an ordered sequence. The first write clears the reset bit, and only the next write may turn the converter and amplifier enables back on. At each soft reset the block sends one pulse to a neighbouring settings store. The pulse either tells that store to keep its contents or tells it to clear them, depending on the preserve flag.

Each clock code maps to a divide or multiply ratio from 2 to 16, and code 0 stands for 16. Code 1 is forbidden. A write that carries it is refused as a whole and raises a sticky error flag.

Top module: `pwr_ctl_bank`

## Requirements
- R1: After synchronous reset (rst=1 at a clock edge) every register output is 0, including the regulator bit, the bias bit and the preserve flag. Both clock codes are 0, both ratios read 16, and the error flag and both strobes are 0.
- R2: Out of soft reset, a write to address 0x05 with data bit 1 = 0 loads the register as follows: bits 7..4 go to aux_en[3:0], bit 3 to lna_on, bit 2 to keep_cfg and bit 0 to vbias_en.
- R3: Out of soft reset, a write to address 0x04 loads all 8 data bits into pwr1_q.
- R4: A write to 0x05 with data bit 1 = 1 sets soft_rst. It clears aux_en, lna_on and every bit of pwr1_q except bit 5. It leaves keep_cfg, vbias_en, pwr1_q[5] and both clock codes unchanged, whatever the other data bits are.
- R5: In the cycle after each soft-reset write, exactly one strobe pulses. spec_keep_pulse pulses if keep_cfg was 1 before the write, and spec_clear_pulse pulses if it was 0. Both strobes stay 0 in every other cycle.
- R6: While soft_rst is 1, a write to 0x04 takes only data bit 5, and the other bits stay 0. A write to 0x05 with bit 1 = 0 clears soft_rst and loads keep_cfg and vbias_en, while aux_en and lna_on stay 0 until a later write.
- R7: A write to 0x06 in which neither field is 0001 loads bits 7..4 into mult_code and bits 3..0 into ref_div_code. It also clears clk_code_err. Each ratio output equals its code, except that code 0 gives 16.
- R8: A write to 0x06 in which either field is 0001 leaves both codes unchanged and sets clk_code_err. The flag stays set until a valid write to 0x06.
- R9: A write to any address other than 0x04, 0x05 and 0x06 changes no output.
- R10: A write is captured at the clock edge where wr_en is 1, and its effect appears on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| aux_en | output | 4 | Auxiliary converter enables |
| lna_on | output | 1 | External amplifier pin |
| keep_cfg | output | 1 | Preserve flag |
| vbias_en | output | 1 | Bias enable |
| soft_rst | output | 1 | Soft-reset bit |
| pwr1_q | output | 8 | First power register |
| ref_div_code | output | 4 | Reference divider code |
| mult_code | output | 4 | Base-clock multiplier code |
| ref_div_ratio | output | 5 | Decoded divider ratio, 2..16 |
| mult_ratio | output | 5 | Decoded multiplier ratio, 2..16 |
| clk_code_err | output | 1 | Sticky flag for a forbidden clock code |
| spec_keep_pulse | output | 1 | One-cycle request to keep settings |
| spec_clear_pulse | output | 1 | One-cycle request to clear settings |

## Verification
Some properties hold on every cycle, and the embedded assertions check them. No stored clock code is ever 0001. The ratios stay within 2..16. The converter and amplifier enables are 0 whenever soft reset is held. The two strobes never fire together, and each fires only after a soft-reset write. A soft-reset write leaves the protected bits alone.

Other behaviour only shows up across a sequence of writes, so the bench scenarios cover it. These scenarios include the ordered exit from reset, the refused clock writes that keep the old codes while the flag stays sticky, the ignored unmapped addresses, and the choice of strobe made from the preserve flag.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int DW       = 8;
  localparam int AW       = 8;
  localparam int AUX_N    = 4;
  localparam int CODE_W   = 4;
  localparam int RATIO_W  = CODE_W + 1;
  localparam int VREG_BIT = 5;

  localparam logic [AW-1:0] ADDR_PWR1 = 8'h04;
  localparam logic [AW-1:0] ADDR_PWR2 = 8'h05;
  localparam logic [AW-1:0] ADDR_CLK  = 8'h06;

  localparam logic [CODE_W-1:0] CODE_BAD = 4'b0001;

  typedef struct packed {
    logic [AUX_N-1:0] aux;
    logic             lna;
    logic             keep;
    logic             srst;
    logic             vbias;
  } pwr2_t;
endpackage

// File: rtl/wr_decode.sv
module wr_decode
  import pwr_ctl_pkg::*;
(
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic          sel_p1,
  output logic          sel_p2,
  output logic          sel_ck
);
  always_comb begin
    sel_p1 = we && (addr == ADDR_PWR1);
    sel_p2 = we && (addr == ADDR_PWR2);
    sel_ck = we && (addr == ADDR_CLK);
  end
endmodule

// File: rtl/pwr_reg_file.sv
module pwr_reg_file
  import pwr_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_p1,
  input  logic          sel_p2,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] p1_q,
  output pwr2_t         p2_q,
  output logic          keep_pls,
  output logic          clr_pls
);
  localparam logic [DW-1:0] P1_KEEP = DW'(1) << VREG_BIT;

  pwr2_t wr_p2;
  logic  srst_req;

  always_comb begin
    wr_p2    = pwr2_t'(wdata);
    srst_req = sel_p2 && wr_p2.srst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_q     <= '0;
      p2_q     <= '0;
      keep_pls <= 1'b0;
      clr_pls  <= 1'b0;
    end else begin
      keep_pls <= srst_req && p2_q.keep;
      clr_pls  <= srst_req && !p2_q.keep;
      if (srst_req) begin
        p2_q.aux  <= '0;
        p2_q.lna  <= 1'b0;
        p2_q.srst <= 1'b1;
        p1_q      <= p1_q & P1_KEEP;
      end else begin
        if (sel_p2) begin
          p2_q.keep  <= wr_p2.keep;
          p2_q.vbias <= wr_p2.vbias;
          p2_q.srst  <= 1'b0;
          if (!p2_q.srst) begin
            p2_q.aux <= wr_p2.aux;
            p2_q.lna <= wr_p2.lna;
          end
        end
        if (sel_p1) begin
          if (p2_q.srst) p1_q <= wdata & P1_KEEP;
          else           p1_q <= wdata;
        end
      end
    end
  end

  // R6
  enables_off_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    p2_q.srst |-> (p2_q.aux == '0 && !p2_q.lna));

  // R5
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(keep_pls && clr_pls));

  // R4
  protected_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
    srst_req |=> ($stable(p2_q.keep) && $stable(p2_q.vbias) && $stable(p1_q[VREG_BIT])));
endmodule

// File: rtl/clk_ctl_reg.sv
module clk_ctl_reg
  import pwr_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [DW-1:0]     wdata,
  output logic [CODE_W-1:0] mult_q,
  output logic [CODE_W-1:0] div_q,
  output logic              err_q
);
  logic [CODE_W-1:0] w_mult;
  logic [CODE_W-1:0] w_div;
  logic              bad;

  always_comb begin
    w_mult = wdata[2*CODE_W-1:CODE_W];
    w_div  = wdata[CODE_W-1:0];
    bad    = (w_mult == CODE_BAD) || (w_div == CODE_BAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q <= '0;
      div_q  <= '0;
      err_q  <= 1'b0;
    end else if (sel) begin
      if (bad) begin
        err_q <= 1'b1;
      end else begin
        mult_q <= w_mult;
        div_q  <= w_div;
        err_q  <= 1'b0;
      end
    end
  end

  // R8
  no_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (mult_q != CODE_BAD) && (div_q != CODE_BAD));

  // R8
  bad_write_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && bad) |=> ($stable(mult_q) && $stable(div_q) && err_q));
endmodule

// File: rtl/pwr_ctl_bank.sv
module pwr_ctl_bank
  import pwr_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [AUX_N-1:0]   aux_en,
  output logic               lna_on,
  output logic               keep_cfg,
  output logic               vbias_en,
  output logic               soft_rst,
  output logic [DW-1:0]      pwr1_q,
  output logic [CODE_W-1:0]  ref_div_code,
  output logic [CODE_W-1:0]  mult_code,
  output logic [RATIO_W-1:0] ref_div_ratio,
  output logic [RATIO_W-1:0] mult_ratio,
  output logic               clk_code_err,
  output logic               spec_keep_pulse,
  output logic               spec_clear_pulse
);
  logic  sel_p1, sel_p2, sel_ck;
  pwr2_t p2;
  logic [CODE_W-1:0]  codes  [2];
  logic [RATIO_W-1:0] ratios [2];

  wr_decode u_dec (
    .we(wr_en), .addr(wr_addr),
    .sel_p1(sel_p1), .sel_p2(sel_p2), .sel_ck(sel_ck)
  );

  pwr_reg_file u_pwr (
    .clk(clk), .rst(rst), .sel_p1(sel_p1), .sel_p2(sel_p2), .wdata(wr_data),
    .p1_q(pwr1_q), .p2_q(p2), .keep_pls(spec_keep_pulse), .clr_pls(spec_clear_pulse)
  );

  clk_ctl_reg u_clk (
    .clk(clk), .rst(rst), .sel(sel_ck), .wdata(wr_data),
    .mult_q(mult_code), .div_q(ref_div_code), .err_q(clk_code_err)
  );

  always_comb begin
    codes[0] = ref_div_code;
    codes[1] = mult_code;
  end

  for (genvar g = 0; g < 2; g++) begin : g_ratio
    always_comb begin
      if (codes[g] == '0) ratios[g] = RATIO_W'(1) << CODE_W;
      else                ratios[g] = RATIO_W'(codes[g]);
    end
  end

  always_comb begin
    aux_en        = p2.aux;
    lna_on        = p2.lna;
    keep_cfg      = p2.keep;
    vbias_en      = p2.vbias;
    soft_rst      = p2.srst;
    ref_div_ratio = ratios[0];
    mult_ratio    = ratios[1];
  end

  // R7
  ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_div_ratio >= 2) && (ref_div_ratio <= 16) && (mult_ratio >= 2) && (mult_ratio <= 16));

  // R5
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (spec_keep_pulse || spec_clear_pulse) |-> $past(wr_en && wr_addr == ADDR_PWR2 && wr_data[1]));

  // R9
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ADDR_PWR1 && wr_addr != ADDR_PWR2 && wr_addr != ADDR_CLK)
      |=> ($stable(pwr1_q) && $stable(aux_en) && $stable(mult_code) && $stable(ref_div_code)));
endmodule

// File: tb/pwr_ctl_bank_tb.sv
module pwr_ctl_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [3:0] aux_en;
  logic lna_on, keep_cfg, vbias_en, soft_rst;
  logic [7:0] pwr1_q;
  logic [3:0] ref_div_code, mult_code;
  logic [4:0] ref_div_ratio, mult_ratio;
  logic clk_code_err, spec_keep_pulse, spec_clear_pulse;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] m_p1;
  logic [3:0] m_aux, m_mc, m_dc;
  logic m_lna, m_keep, m_rst, m_vb, m_err, e_keep, e_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_ctl_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .aux_en(aux_en), .lna_on(lna_on), .keep_cfg(keep_cfg), .vbias_en(vbias_en),
    .soft_rst(soft_rst), .pwr1_q(pwr1_q), .ref_div_code(ref_div_code),
    .mult_code(mult_code), .ref_div_ratio(ref_div_ratio), .mult_ratio(mult_ratio),
    .clk_code_err(clk_code_err), .spec_keep_pulse(spec_keep_pulse),
    .spec_clear_pulse(spec_clear_pulse)
  );

  function automatic logic [4:0] ratio_of(input logic [3:0] c);
    return (c == 4'd0) ? 5'd16 : {1'b0, c};
  endfunction

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req, "pwr1_q", pwr1_q, m_p1);
    cmp(req, "pwr2", {aux_en, lna_on, keep_cfg, soft_rst, vbias_en},
        {m_aux, m_lna, m_keep, m_rst, m_vb});
    cmp(req, "codes", {mult_code, ref_div_code}, {m_mc, m_dc});
    cmp(req, "ratios", {mult_ratio, ref_div_ratio}, {ratio_of(m_mc), ratio_of(m_dc)});
    cmp(req, "err", clk_code_err, m_err);
    cmp(req, "strobes", {spec_keep_pulse, spec_clear_pulse}, {e_keep, e_clr});
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    e_keep = 1'b0;
    e_clr  = 1'b0;
    if (a == 8'h04) begin
      m_p1 = m_rst ? (d & 8'h20) : d;
    end else if (a == 8'h05) begin
      if (d[1]) begin
        e_keep = m_keep;
        e_clr  = !m_keep;
        m_aux = 4'd0; m_lna = 1'b0; m_rst = 1'b1;
        m_p1  = m_p1 & 8'h20;
      end else begin
        if (!m_rst) begin m_aux = d[7:4]; m_lna = d[3]; end
        m_keep = d[2]; m_vb = d[0]; m_rst = 1'b0;
      end
    end else if (a == 8'h06) begin
      if (d[7:4] == 4'd1 || d[3:0] == 4'd1) m_err = 1'b1;
      else begin m_mc = d[7:4]; m_dc = d[3:0]; m_err = 1'b0; end
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] a, d;
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    m_p1 = '0; m_aux = '0; m_mc = '0; m_dc = '0;
    m_lna = 0; m_keep = 0; m_rst = 0; m_vb = 0; m_err = 0; e_keep = 0; e_clr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    wr(8'h04, 8'hFF, "R3");
    wr(8'h05, 8'hF5, "R2");
    wr(8'h05, 8'hA8, "R2 R10");
    wr(8'h05, 8'h5D, "R2");
    wr(8'h06, 8'h3C, "R7");
    wr(8'h06, 8'h00, "R7");
    wr(8'h06, 8'h1F, "R8");
    wr(8'h06, 8'hF1, "R8");
    wr(8'h06, 8'h99, "R8 R7");
    wr(8'h07, 8'hFF, "R9");
    wr(8'h00, 8'h02, "R9");
    wr(8'h05, 8'hFF, "R4 R5");
    @(negedge clk); e_keep = 0; e_clr = 0; check_all("R5");
    wr(8'h04, 8'hFF, "R6");
    wr(8'h05, 8'hF0, "R6");
    wr(8'h05, 8'hF8, "R6 R2");
    wr(8'h05, 8'h02, "R4 R5");
    wr(8'h05, 8'h06, "R4 R5");
    wr(8'h05, 8'h00, "R6");

    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 4))
        0: a = 8'h04;
        1: a = 8'h05;
        2: a = 8'h06;
        3: a = 8'h05;
        default: a = 8'($urandom_range(7, 255));
      endcase
      d = 8'($urandom);
      if (a == 8'h06 && $urandom_range(0, 3) == 0) d[3:0] = 4'd1;
      wr(a, d, "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_p1 = '0; m_aux = '0; m_mc = '0; m_dc = '0;
    m_lna = 0; m_keep = 0; m_rst = 0; m_vb = 0; m_err = 0; e_keep = 0; e_clr = 0;
    @(negedge clk);
    check_all("R1");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule